// File: doc/BRIEF.md
# Capture/Reload Up-Down Timer

This block is a 16-bit timer/event counter paired with a 16-bit register that serves either as a capture latch or as a reload value. It advances either once per machine cycle (six clocks by default) or once per sampled falling edge of an event input. An external trigger input, checked once per machine cycle, can latch the running count, force a reload, or set the counting direction. Which of these it does depends on the mode selected.

Three modes come from two select inputs. In capture mode the count runs freely and a trigger fall latches it. In reload mode the count runs up and restarts from the reload value. When reload mode is combined with the direction enable, the trigger level picks up or down counting, and the external flag acts as a seventeenth count bit. Two sticky flags (overflow and external) stay set until software clears them. The interrupt request is derived from these flags. Software can also write the count and the capture/reload register directly.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, the capture/reload register, both flags and the interrupt request are all zero.
- R2: With `src_evt` = 0 the count advances by one every `MC_CLKS` clocks (6 by default), so k machine cycles after a software count write the count equals the written value plus k.
- R3: With `src_evt` = 1 the count advances by one for each falling edge of `evt_in` seen between two machine-cycle samples (each level held at least one full machine cycle), and stays still otherwise.
- R4: In capture mode (`mode_reload` = 0) a step from FFFFh gives 0000h and sets `ovf_flag`.
- R5: In capture mode with `ext_en` = 1, a sampled falling edge of `trig_in` copies the count into `rld_val` and sets `ext_flag`. With `ext_en` = 0 the same edge changes neither.
- R6: In reload mode (`mode_reload` = 1, `dir_en` = 0) a step from FFFFh loads `rld_val` into the count and sets `ovf_flag`.
- R7: In reload mode with `ext_en` = 1, a sampled falling edge of `trig_in` loads `rld_val` into the count and sets `ext_flag` without touching `ovf_flag`.
- R8: In up/down mode (`mode_reload` = 1, `dir_en` = 1) with `trig_in` sampled high, the count rises. A step from FFFFh loads `rld_val`, sets `ovf_flag` and inverts `ext_flag`. Trigger edges cause no capture, reload or flag set.
- R9: In up/down mode with `trig_in` sampled low, the count falls. A step taken while the count equals `rld_val` loads FFFFh, sets `ovf_flag` and inverts `ext_flag`.
- R10: In up/down mode, counting down from 0000h to FFFFh while `rld_val` is not 0000h changes neither flag.
- R11: `irq` follows `ovf_flag` alone in up/down mode, and `ovf_flag` OR `ext_flag` in the other modes.
- R12: Both flags hold their value until `ovf_clr` / `ext_clr` clears them (a flag set event in the same cycle wins). A count write takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 1 | 0: step per machine cycle, 1: step per `evt_in` falling edge |
| mode_reload | input | 1 | 0: capture mode, 1: reload mode |
| dir_en | input | 1 | In reload mode, lets the trigger level set direction |
| ext_en | input | 1 | Enables trigger-edge capture/reload |
| evt_in | input | 1 | External event input for counter mode |
| trig_in | input | 1 | External trigger / direction input |
| cnt_wr_en | input | 1 | Software write strobe for the count |
| cnt_wr_data | input | 16 | Value written to the count |
| rld_wr_en | input | 1 | Software write strobe for the capture/reload register |
| rld_wr_data | input | 16 | Value written to the capture/reload register |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_clr | input | 1 | Clears the external flag |
| count | output | 16 | Current count |
| rld_val | output | 16 | Capture/reload register |
| ovf_flag | output | 1 | Sticky overflow/underflow flag |
| ext_flag | output | 1 | Sticky external flag / seventeenth bit |
| irq | output | 1 | Interrupt request |

## Verification
Timer stepping is swept over several start values and machine-cycle counts. This shows an off-by-one in the prescaler or in the increment apart from a correct run. Event counting uses bursts of one to four pulses, which separates edge detection from level detection. The mode boundaries are driven at FFFEh/FFFFh going up, at the reload value and at 0000h going down, and with trigger falls both enabled and disabled. Together these separate overflow from underflow, equality-based underflow from zero wrap, capture from reload, and a flag set from a toggle. The interrupt is checked with only the external flag set in each mode family, which shows whether that flag is masked.

// File: rtl/cap_reload_timer_pkg.sv
// Shared types for the capture/reload timer.
// Assumes: one mode is active at a time, decoded from two select inputs.
package cap_reload_timer_pkg;

    typedef enum logic [1:0] {
        TMODE_CAPTURE = 2'd0,
        TMODE_RELOAD  = 2'd1,
        TMODE_UPDOWN  = 2'd2
    } tmr_mode_e;

    // Folds the two select inputs into one operating mode.
    function automatic tmr_mode_e decode_mode(input logic reload_sel, input logic updown_sel);
        if (!reload_sel)     return TMODE_CAPTURE;
        else if (updown_sel) return TMODE_UPDOWN;
        else                 return TMODE_RELOAD;
    endfunction

endpackage

// File: rtl/mc_prescaler.sv
// Machine-cycle strobe generator: emits a one-clock tick every MC_CLKS clocks.
// Assumes: MC_CLKS >= 2; the phase restarts at reset.
module mc_prescaler #(
    parameter int MC_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (MC_CLKS > 2) ? $clog2(MC_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(MC_CLKS - 1);

    logic [PW-1:0] phase;

    // Free-running phase counter, wraps at the last clock of a machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/mc_level_sampler.sv
// Samples N input pins once per machine cycle and holds the sampled levels.
// Assumes: inputs are held for at least one machine cycle; a falling edge is
// the held level being high while the pin reads low at the next tick.
module mc_level_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_smp
        // Latch the pin level at each machine-cycle tick.
        always_ff @(posedge clk) begin
            if (!rst_n)    lvl[i] <= 1'b0;
            else if (tick) lvl[i] <= pin[i];
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
// Count register and its next-value logic for all three modes.
// Assumes: step and trig_fall are single-cycle pulses; trig_fall is already
// gated by the trigger enable. A software write overrides every event.
module tmr_count_core
    import cap_reload_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic         down,
    input  logic         step,
    input  logic         trig_fall,
    input  logic [W-1:0] rld_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         ovf_evt,
    output logic         ext_set,
    output logic         ext_tgl,
    output logic         cap_evt
);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] nxt;

    // Next count and event pulses for the current step and trigger.
    always_comb begin
        nxt     = count;
        ovf_evt = 1'b0;
        ext_set = 1'b0;
        ext_tgl = 1'b0;
        cap_evt = 1'b0;
        if (step) begin
            if (mode == TMODE_UPDOWN) begin
                if (down) begin
                    if (count == rld_val) begin
                        nxt     = CMAX;
                        ovf_evt = 1'b1;
                        ext_tgl = 1'b1;
                    end else begin
                        nxt = count - 1'b1;
                    end
                end else if (count == CMAX) begin
                    nxt     = rld_val;
                    ovf_evt = 1'b1;
                    ext_tgl = 1'b1;
                end else begin
                    nxt = count + 1'b1;
                end
            end else if (count == CMAX) begin
                nxt     = (mode == TMODE_RELOAD) ? rld_val : '0;
                ovf_evt = 1'b1;
            end else begin
                nxt = count + 1'b1;
            end
        end
        if (trig_fall && mode != TMODE_UPDOWN) begin
            ext_set = 1'b1;
            if (mode == TMODE_RELOAD) nxt = rld_val;
            else                      cap_evt = 1'b1;
        end
        if (wr_en) begin
            ovf_evt = 1'b0;
            ext_set = 1'b0;
            ext_tgl = 1'b0;
            cap_evt = 1'b0;
        end
    end

    // Count register: software write first, else the computed next value.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (wr_en) count <= wr_data;
        else            count <= nxt;
    end
endmodule

// File: rtl/cap_reload_timer.sv
// Top of the capture/reload up-down timer: machine-cycle timing, input
// sampling, count core, capture/reload register, sticky flags and interrupt.
// Assumes: software clears flags through the clear strobes; evt_in and trig_in
// are synchronous to clk and held at least one machine cycle per level.
module cap_reload_timer
    import cap_reload_timer_pkg::*;
#(
    parameter int W       = 16,
    parameter int MC_CLKS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_evt,
    input  logic         mode_reload,
    input  logic         dir_en,
    input  logic         ext_en,
    input  logic         evt_in,
    input  logic         trig_in,
    input  logic         cnt_wr_en,
    input  logic [W-1:0] cnt_wr_data,
    input  logic         rld_wr_en,
    input  logic [W-1:0] rld_wr_data,
    input  logic         ovf_clr,
    input  logic         ext_clr,
    output logic [W-1:0] count,
    output logic [W-1:0] rld_val,
    output logic         ovf_flag,
    output logic         ext_flag,
    output logic         irq
);
    localparam int SMP_N    = 2;
    localparam int IDX_TRIG = 0;
    localparam int IDX_EVT  = 1;

    logic             tick;
    logic [SMP_N-1:0] smp_pin, smp_lvl;
    logic             trig_fall, evt_fall, step;
    tmr_mode_e        mode;
    logic             ovf_evt, ext_set, ext_tgl, cap_evt;

    mc_prescaler #(.MC_CLKS(MC_CLKS)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign smp_pin[IDX_TRIG] = trig_in;
    assign smp_pin[IDX_EVT]  = evt_in;

    mc_level_sampler #(.N(SMP_N)) u_smp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(smp_pin), .lvl(smp_lvl)
    );

    assign trig_fall = tick & smp_lvl[IDX_TRIG] & ~trig_in & ext_en;
    assign evt_fall  = tick & smp_lvl[IDX_EVT] & ~evt_in;
    assign step      = src_evt ? evt_fall : tick;
    assign mode      = decode_mode(mode_reload, dir_en);

    tmr_count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode), .down(~smp_lvl[IDX_TRIG]),
        .step(step), .trig_fall(trig_fall), .rld_val(rld_val),
        .wr_en(cnt_wr_en), .wr_data(cnt_wr_data), .count(count),
        .ovf_evt(ovf_evt), .ext_set(ext_set), .ext_tgl(ext_tgl), .cap_evt(cap_evt)
    );

    // Capture/reload register: software write, else capture of the count.
    always_ff @(posedge clk) begin
        if (!rst_n)         rld_val <= '0;
        else if (rld_wr_en) rld_val <= rld_wr_data;
        else if (cap_evt)   rld_val <= count;
    end

    // Overflow flag: set by an event, held until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_evt) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    // External flag: set by a trigger, inverted as the 17th bit, or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)       ext_flag <= 1'b0;
        else if (ext_set) ext_flag <= 1'b1;
        else if (ext_tgl) ext_flag <= ~ext_flag;
        else if (ext_clr) ext_flag <= 1'b0;
    end

    // Interrupt: the external flag is masked in up/down mode.
    always_comb begin
        irq = (mode == TMODE_UPDOWN) ? ovf_flag : (ovf_flag | ext_flag);
    end
endmodule

// File: rtl/cap_reload_timer_chk.sv
// Property checker for cap_reload_timer, attached with bind below.
// Assumes: the default width of 16 bits.
module cap_reload_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_reload,
    input logic        dir_en,
    input logic        cnt_wr_en,
    input logic        rld_wr_en,
    input logic        ovf_clr,
    input logic        ext_clr,
    input logic [15:0] count,
    input logic [15:0] rld_val,
    input logic        ovf_flag,
    input logic        ext_flag,
    input logic        irq
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (count == 16'h0 && rld_val == 16'h0 && !ovf_flag && !ext_flag));

    p_capture_sets_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rld_val) && !$past(rld_wr_en) && !$past(mode_reload)) |-> ext_flag);

    p_reload_on_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && $past(mode_reload) && !$past(dir_en)
         && !$past(cnt_wr_en) && !$past(rld_wr_en)) |-> (count == rld_val));

    p_irq_from_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> irq);

    p_irq_mask_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reload && dir_en && !ovf_flag) |-> !irq);

    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_ext_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !ext_clr && !(mode_reload && dir_en)) |=> ext_flag);
endmodule

bind cap_reload_timer cap_reload_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mode_reload(mode_reload), .dir_en(dir_en),
    .cnt_wr_en(cnt_wr_en), .rld_wr_en(rld_wr_en), .ovf_clr(ovf_clr),
    .ext_clr(ext_clr), .count(count), .rld_val(rld_val),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq)
);

// File: tb/cap_reload_timer_tb_top.sv
// Self-checking bench: sweeps start values and step counts, and drives every
// mode across its boundaries. Expected values are computed here.
module cap_reload_timer_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_evt = 1'b0, mode_reload = 1'b0, dir_en = 1'b0, ext_en = 1'b0;
    logic        evt_in = 1'b0, trig_in = 1'b1;
    logic        cnt_wr_en = 1'b0, rld_wr_en = 1'b0, ovf_clr = 1'b0, ext_clr = 1'b0;
    logic [15:0] cnt_wr_data = '0, rld_wr_data = '0;
    logic [15:0] count, rld_val;
    logic        ovf_flag, ext_flag, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_reload_timer dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .mode_reload(mode_reload),
        .dir_en(dir_en), .ext_en(ext_en), .evt_in(evt_in), .trig_in(trig_in),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .rld_wr_en(rld_wr_en), .rld_wr_data(rld_wr_data),
        .ovf_clr(ovf_clr), .ext_clr(ext_clr), .count(count), .rld_val(rld_val),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(posedge clk); #1 cnt_wr_en = 1'b0;
    endtask

    task automatic wr_rld(input logic [15:0] v);
        @(negedge clk); rld_wr_en = 1'b1; rld_wr_data = v;
        @(posedge clk); #1 rld_wr_en = 1'b0;
    endtask

    task automatic clr_flags(input logic o, input logic e);
        @(negedge clk); ovf_clr = o; ext_clr = e;
        @(posedge clk); #1 ovf_clr = 1'b0; ext_clr = 1'b0;
    endtask

    task automatic wait_mc(input int k);
        repeat (MC*k) @(posedge clk);
        #1;
    endtask

    task automatic evt_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1; repeat (2*MC) @(posedge clk);
            evt_in = 1'b0; repeat (2*MC) @(posedge clk);
        end
        #1;
    endtask

    task automatic trig_fall_seq();
        trig_in = 1'b0; repeat (2*MC) @(posedge clk);
        trig_in = 1'b1; repeat (2*MC) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 count", count, 0);
        chk("R1 rld", rld_val, 0);
        chk("R1 flags/irq", {ovf_flag, ext_flag, irq}, 0);
        rst_n = 1'b1;

        // R2: timer-mode sweep over start values and machine-cycle counts.
        for (int b = 0; b < 4; b++) begin
            for (int k = 1; k <= 5; k++) begin
                logic [15:0] base;
                base = 16'(b * 16'h2345);
                wr_cnt(base);
                wait_mc(k);
                chk("R2 timer step", count, 16'(base + k));
            end
        end

        // R4: capture mode overflow; R12 sticky; R11 irq.
        wr_cnt(16'hFFFE);
        wait_mc(1);
        chk("R4 at FFFF", {ovf_flag, count}, {1'b0, 16'hFFFF});
        wait_mc(1);
        chk("R4 wrap sets ovf", {ovf_flag, count}, {1'b1, 16'h0000});
        chk("R11 irq on ovf", irq, 1);
        wait_mc(3);
        chk("R12 ovf sticky", ovf_flag, 1);
        clr_flags(1'b1, 1'b1);
        chk("R12 ovf cleared", {ovf_flag, irq}, 0);

        // R3: event counting with bursts.
        src_evt = 1'b1;
        wr_cnt(16'h0100);
        begin
            int total;
            total = 0;
            for (int n = 1; n <= 4; n++) begin
                evt_pulses(n);
                total += n;
                chk("R3 event count", count, 16'(16'h0100 + total));
            end
        end
        wait_mc(4);
        chk("R3 idle holds", count, 16'h010A);

        // R5: capture with trigger disabled then enabled.
        wr_cnt(16'hBEEF);
        wr_rld(16'h0000);
        ext_en = 1'b0;
        trig_fall_seq();
        chk("R5 disabled no capture", {ext_flag, rld_val}, {1'b0, 16'h0000});
        ext_en = 1'b1;
        trig_fall_seq();
        chk("R5 captured", {ext_flag, rld_val, count}, {1'b1, 16'hBEEF, 16'hBEEF});
        chk("R11 irq on ext capture mode", irq, 1);
        wait_mc(2);
        chk("R12 ext sticky", ext_flag, 1);
        clr_flags(1'b1, 1'b1);

        // R6: reload on overflow, timer mode.
        mode_reload = 1'b1; src_evt = 1'b0; ext_en = 1'b0;
        wr_rld(16'hFF00);
        wr_cnt(16'hFFFD);
        wait_mc(3);
        chk("R6 reload on ovf", {ovf_flag, count}, {1'b1, 16'hFF00});
        wait_mc(2);
        chk("R6 counts on", count, 16'hFF02);
        clr_flags(1'b1, 1'b1);

        // R7: trigger reload, counter mode static.
        src_evt = 1'b1; ext_en = 1'b1;
        wr_rld(16'h4242);
        wr_cnt(16'h0007);
        trig_fall_seq();
        chk("R7 trigger reload", {ovf_flag, ext_flag, count}, {1'b0, 1'b1, 16'h4242});
        chk("R11 irq on ext reload mode", irq, 1);
        clr_flags(1'b1, 1'b1);

        // R8: up/down mode counting up.
        dir_en = 1'b1; src_evt = 1'b0;
        wait_mc(2);
        wr_rld(16'h1234);
        wr_cnt(16'hFFFE);
        wait_mc(2);
        chk("R8 up overflow", {ovf_flag, ext_flag, count}, {1'b1, 1'b1, 16'h1234});
        clr_flags(1'b1, 1'b0);
        chk("R11 ext masked", {ext_flag, irq}, {1'b1, 1'b0});
        wr_cnt(16'hFFFF);
        wait_mc(1);
        chk("R8 ext toggles back", {ovf_flag, ext_flag, count}, {1'b1, 1'b0, 16'h1234});
        clr_flags(1'b1, 1'b1);

        // R9: counting down, underflow at the reload value; trigger falls ignored.
        trig_in = 1'b0;
        wait_mc(2);
        wr_rld(16'h0010);
        wr_cnt(16'h0012);
        wait_mc(2);
        chk("R9 before underflow", {ovf_flag, count}, {1'b0, 16'h0010});
        wait_mc(1);
        chk("R9 underflow", {ovf_flag, ext_flag, count}, {1'b1, 1'b1, 16'hFFFF});
        wait_mc(1);
        chk("R9 continues down", count, 16'hFFFE);
        for (int k = 1; k <= 4; k++) begin
            wr_cnt(16'h0800);
            wait_mc(k);
            chk("R9 down sweep", count, 16'(16'h0800 - k));
        end
        clr_flags(1'b1, 1'b1);

        // R10: zero wrap while counting down is not an underflow.
        wr_rld(16'h0100);
        wr_cnt(16'h0001);
        wait_mc(2);
        chk("R10 zero wrap", {ovf_flag, ext_flag, count}, {1'b0, 1'b0, 16'hFFFF});

        // R12: write beats a step in the same cycle; count equals written value.
        wr_cnt(16'h0100);
        chk("R12 write wins", {ovf_flag, count}, {1'b0, 16'h0100});
        trig_in = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule